// File: doc/BRIEF.md
# Cascadable Programmable Clock Divider

This block divides an input clock by an integer ratio N. A chain of identical 6-bit down-counter slices forms it. Each slice exposes a parallel preset value, a ripple carry pair (carry in and terminal-count out) and an all-zero flag. A look-ahead network builds each slice's carry input from the all-zero flags of every lower slice. The slice next to the clock-entry end is the least significant one, and its carry input is tied permanently active. The chain width is the slice count times six.

A single shared reload gate watches the slices. When no slice holds a nonzero value, the gate asserts reload to every slice in the same clock. Reloading is synchronous and uses up one count state, so the user programs the word N−1 to divide by N. The divided output is registered and is high for one input clock per period. A second register provides its complement, so either polarity can be used.

While reset is high, the chain is preset from the ratio word. The first output pulse therefore follows the release of reset by exactly N clocks.

Top module: `cascade_clk_div`

## Requirements
- R1: With `ratio_word` = N−1 (N from 2 to 2^(6·NUM_SLICES)), `div_out` rises once every N input clocks. The interval between consecutive pulses is always exactly N.
- R2: While `rst` is high, the chain loads `ratio_word`. The first `div_out` pulse is observed after exactly N rising clock edges following the release of reset.
- R3: For N ≥ 2, `div_out` stays high for exactly one input clock per period.
- R4: `div_out_n` is the logical complement of `div_out` in every cycle.
- R5: While `rst` is asserted, `div_out` is 0 and `div_out_n` is 1.
- R6: A configuration with a single slice (NUM_SLICES = 1) divides correctly for every ratio from 2 to 64 inclusive.
- R7: A change of `ratio_word` during a period does not alter that period. The new value is taken only at the next reload.
- R8: A slice decrements only when all lower slices are zero. Ratios whose N−1 has bits in higher slices (65, 4097, 65537) therefore divide exactly.
- R9: Terminal count is recognised only when every slice is zero. The shared reload gate then loads all slices in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; presets the chain from `ratio_word` |
| ratio_word | input | 6·NUM_SLICES | Divide word, equal to the ratio minus one |
| div_out | output | 1 | Registered one-clock pulse per division period |
| div_out_n | output | 1 | Registered complement of `div_out` |

## Verification
A one-slice instance is swept over every ratio from 2 to 64. This shows that the smallest and largest single-slice words reload with the right state count. The four-slice instance runs ratios 2, 3, 37 and 64, which stay within the lowest slice, and ratios 65, 4097 and 65537, which need borrows from the second and third slices. Each of those pulse intervals separates a correct look-ahead carry from an off-by-one or a missed borrow. A word change made right after a pulse tells a reload-time sample apart from a live one, because the period in progress keeps the old length.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int unsigned SLICE_BITS = 6;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } slice_act_e;

    typedef struct packed {
        logic zero;   // slice holds zero (look-ahead carry-out)
        logic tc;     // zero and carry-in active (ripple carry-out)
    } slice_flags_t;

    function automatic slice_act_e pick_action(input logic force_load, input logic carry_in);
        if (force_load)
            return ACT_LOAD;
        else if (carry_in)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/cdiv_slice.sv
module cdiv_slice #(
    parameter int unsigned W = cdiv_pkg::SLICE_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  cin,
    input  logic [W-1:0]          preset,
    output logic [W-1:0]          count,
    output cdiv_pkg::slice_flags_t flags
);
    import cdiv_pkg::*;

    slice_act_e act;

    always_comb begin
        act = pick_action(rst | load, cin);
    end

    always_ff @(posedge clk) begin
        case (act)
            ACT_LOAD: count <= preset;
            ACT_STEP: count <= count - 1'b1;
            default:  count <= count;
        endcase
    end

    always_comb begin
        flags.zero = (count == '0);
        flags.tc   = flags.zero & cin;
    end

    // R8: an enabled slice moves down by one, wrapping from zero
    p_step_down_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && cin) |=> (count == $past(count) - 1'b1));

    // R8: a slice without carry-in keeps its value
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin) |=> $stable(count));

    // R9: a reload copies the preset into the slice
    p_load_copy_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(preset)));

endmodule

// File: rtl/cdiv_lookahead.sv
module cdiv_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] zero_vec,
    output logic [N-1:0] cin_vec
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_cin
            if (i == 0) begin : g_lsb
                assign cin_vec[i] = 1'b1;
            end else begin : g_upper
                assign cin_vec[i] = &zero_vec[i-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/cdiv_reload_gate.sv
module cdiv_reload_gate #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] busy_vec,
    output logic         reload
);
    // OR-type combine of per-slice "still counting" flags, inverted
    assign reload = ~(|busy_vec);

endmodule

// File: rtl/cdiv_outreg.sv
module cdiv_outreg (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse,
    output logic pulse_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= 1'b0;
            pulse_n <= 1'b1;
        end else begin
            pulse   <= fire;
            pulse_n <= ~fire;
        end
    end

    // R4: the two output registers always disagree
    p_complement_r4: assert property (@(posedge clk) disable iff (rst)
        (pulse_n == !pulse));

endmodule

// File: rtl/cascade_clk_div.sv
module cascade_clk_div #(
    parameter int unsigned NUM_SLICES = 4,
    parameter int unsigned SLICE_W    = cdiv_pkg::SLICE_BITS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SLICES*SLICE_W-1:0]   ratio_word,
    output logic                            div_out,
    output logic                            div_out_n
);
    import cdiv_pkg::*;

    localparam int unsigned TOTAL_W = NUM_SLICES * SLICE_W;
    localparam int unsigned MSB_IDX = NUM_SLICES - 1;

    logic [NUM_SLICES-1:0] zero_vec;
    logic [NUM_SLICES-1:0] tc_vec;
    logic [NUM_SLICES-1:0] cin_vec;
    logic [NUM_SLICES-1:0] busy_vec;
    logic [TOTAL_W-1:0]    full_count;
    logic                  reload;

    cdiv_lookahead #(.N(NUM_SLICES)) u_la (
        .zero_vec (zero_vec),
        .cin_vec  (cin_vec)
    );

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            slice_flags_t fl;

            cdiv_slice #(.W(SLICE_W)) u_slice (
                .clk    (clk),
                .rst    (rst),
                .load   (reload),
                .cin    (cin_vec[s]),
                .preset (ratio_word[s*SLICE_W +: SLICE_W]),
                .count  (full_count[s*SLICE_W +: SLICE_W]),
                .flags  (fl)
            );

            assign zero_vec[s] = fl.zero;
            assign tc_vec[s]   = fl.tc;
            assign busy_vec[s] = ~fl.zero;
        end
    endgenerate

    cdiv_reload_gate #(.N(NUM_SLICES)) u_gate (
        .busy_vec (busy_vec),
        .reload   (reload)
    );

    cdiv_outreg u_out (
        .clk     (clk),
        .rst     (rst),
        .fire    (reload),
        .pulse   (div_out),
        .pulse_n (div_out_n)
    );

    // R9: the shared gate agrees with the top slice's ripple carry-out
    p_gate_matches_carry_r9: assert property (@(posedge clk) disable iff (rst)
        (reload == tc_vec[MSB_IDX]));

    // R8: between reloads the whole chain falls by exactly one
    p_chain_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!reload) |=> (full_count == $past(full_count) - 1'b1));

    // R1: a pulse coincides with the chain holding the freshly loaded word
    p_pulse_reloaded_r1: assert property (@(posedge clk) disable iff (rst)
        div_out |-> (full_count == $past(ratio_word)));

    // R3: with a nonzero word the pulse lasts one clock
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (div_out && ($past(ratio_word) != '0)) |=> !div_out);

endmodule

// File: tb/cascade_clk_div_test.sv
module cascade_clk_div_test;

    localparam int unsigned WATCH_CYCLES = 199000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] word4 = 24'd1;
    logic        out4, out4_n;
    logic        rst1 = 1'b1;
    logic [5:0]  word1 = 6'd1;
    logic        out1, out1_n;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cascade_clk_div #(.NUM_SLICES(4)) uut (
        .clk(clk), .rst(rst), .ratio_word(word4),
        .div_out(out4), .div_out_n(out4_n)
    );

    cascade_clk_div #(.NUM_SLICES(1)) uut_one (
        .clk(clk), .rst(rst1), .ratio_word(word1),
        .div_out(out1), .div_out_n(out1_n)
    );

    function automatic logic cur_out(input int sel);
        return (sel == 1) ? out1 : out4;
    endfunction

    function automatic logic cur_out_n(input int sel);
        return (sel == 1) ? out1_n : out4_n;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // counts rising edges until the output is seen high; reports the
    // value seen right after the first edge
    task automatic wait_pulse(input int sel, input int limit, output int cnt, output logic first);
        cnt = 0;
        first = 1'b0;
        while (1) begin
            @(posedge clk);
            #1;
            cnt++;
            if (cnt == 1) first = cur_out(sel);
            if (cur_out(sel) == 1'b1) break;
            if (cnt > limit) break;
        end
    endtask

    task automatic apply_reset(input int sel, input int n);
        @(negedge clk);
        if (sel == 1) begin word1 = 6'(n - 1); rst1 = 1'b1; end
        else begin word4 = 24'(n - 1); rst = 1'b1; end
        @(negedge clk);
        @(negedge clk);
        // R5: reset state
        check(cur_out(sel) == 1'b0, "R5 out low in reset", cur_out(sel), 0);
        check(cur_out_n(sel) == 1'b1, "R5 out_n high in reset", cur_out_n(sel), 1);
        if (sel == 1) rst1 = 1'b0; else rst = 1'b0;
    endtask

    task automatic run_ratio(input int sel, input int n, input int periods, input string tag);
        int   cnt;
        logic first;
        apply_reset(sel, n);
        wait_pulse(sel, n + 4, cnt, first);
        check(cnt == n, $sformatf("R2 first pulse %s N=%0d", tag, n), cnt, n);
        check(cur_out_n(sel) == 1'b0, $sformatf("R4 complement %s N=%0d", tag, n), cur_out_n(sel), 0);
        for (int p = 0; p < periods; p++) begin
            wait_pulse(sel, n + 4, cnt, first);
            check(cnt == n, $sformatf("%s interval N=%0d", tag, n), cnt, n);
            check(first == 1'b0, $sformatf("R3 width %s N=%0d", tag, n), first, 0);
        end
    endtask

    initial begin : watchdog
        repeat (WATCH_CYCLES) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCH_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int   cnt;
        logic first;

        // R6: every single-slice ratio
        for (int n = 2; n <= 64; n++) begin
            run_ratio(1, n, 2, "R6 one-slice");
        end

        // R1: small ratios in the four-slice chain
        run_ratio(0, 2,  3, "R1");
        run_ratio(0, 3,  3, "R1");
        run_ratio(0, 37, 3, "R1");
        run_ratio(0, 64, 3, "R1");
        // R8: borrows across slice boundaries
        run_ratio(0, 65,   3, "R8");
        run_ratio(0, 4097, 2, "R8");
        // R9: terminal count needs all three lower slices at zero together
        run_ratio(0, 65537, 1, "R9");

        // R7: word change right after a pulse leaves the running period alone
        apply_reset(0, 10);
        wait_pulse(0, 14, cnt, first);
        check(cnt == 10, "R7 first period", cnt, 10);
        word4 = 24'd4;
        wait_pulse(0, 14, cnt, first);
        check(cnt == 10, "R7 period in flight keeps old ratio", cnt, 10);
        wait_pulse(0, 14, cnt, first);
        check(cnt == 5, "R7 new ratio after reload", cnt, 5);
        check(out4_n == ~out4, "R4 complement after change", out4_n, ~out4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule